// File: doc/BRIEF.md
# Debug-line rate synchronizer

This host-side block finds the serial rate of a target on a single-wire debug line. On `start` it pulls the line low for a programmable number of host clocks. It then drives one host-clock high pulse to speed up the rising edge, and releases the line. After that it watches the line through a two-flop synchronizer. The target answers with a low reference pulse that lasts 128 of its own clocks. The block counts the width of that pulse in host clocks. A watchdog window bounds the wait. If no complete pulse arrives inside the window, the result is a zero count, which means no target is attached.

From the count the block derives the timing values that the host bit engine needs. It produces four values, each rounded to the nearest host tick:
- a bit time of 16 target clocks, rounded up so it never falls short;
- a one-pulse width of about 4/16 of a bit;
- a sample threshold of about 10/16 of a bit;
- a zero-pulse width of about 13/16 of a bit.

A count below a programmable minimum, zero included, stands for a rate faster than any supported target. In that case a fixed default count feeds the timing values instead. A nonzero manual count skips the line activity entirely and loads that count directly. A state field tells whether the current values come from no connection, a measurement, or a manual load.

Top module: `sync_rate_meter`

## Requirements
- R1: After reset `link_state` is 0 (no connection), `sync_cnt` is 0, `drv_en` and `done` are 0, and the four timing outputs hold the values derived from `DEF_CNT`.
- R2: A request with `man_cnt` = 0 drives the line low (`drv_en`=1, `drv_val`=0) for max(`req_len`,1) cycles. It then drives exactly one cycle high (`drv_en`=1, `drv_val`=1) and then releases the line (`drv_en`=0).
- R3: After release the block waits for the synchronized line to read high, then for it to fall. `sync_cnt` becomes the number of clock cycles the line stayed low. `done` pulses for one cycle with `link_state` = 1 (synced).
- R4: For a count c at or above `MIN_CNT`, `bit_time` = ceil(c/8), i.e. floor((16c+127)/128).
- R5: For c at or above `MIN_CNT`, `one_time` = floor((4c+64)/128), `thr_time` = floor((10c+64)/128) and `zero_time` = floor((13c+64)/128).
- R6: When c is below `MIN_CNT`, all four timing outputs use `DEF_CNT` in place of c, while `sync_cnt` still reports c.
- R7: If the release-to-rising-edge sequence is not complete within `tmo_len` cycles of release, `done` pulses with `sync_cnt` = 0, `link_state` = 0 and default timing.
- R8: `start` with a nonzero `man_cnt` leaves `drv_en` at 0, pulses `done` on the next cycle, sets `link_state` = 2 (manual), loads `sync_cnt` = `man_cnt`, and derives the timing from it under R4 to R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a request (ignored while busy) |
| req_len | input | CW | Request low time in host clocks |
| tmo_len | input | CW | Measurement window in host clocks |
| man_cnt | input | CW | Manual count; nonzero skips measurement |
| line_in | input | 1 | Raw debug line level |
| drv_en | output | 1 | Drive enable for the line buffer |
| drv_val | output | 1 | Level driven when enabled |
| busy | output | 1 | Request or measurement in progress |
| done | output | 1 | One-cycle pulse when results update |
| link_state | output | 2 | 0 none, 1 synced, 2 manual |
| sync_cnt | output | CW | Measured or loaded reference count |
| bit_time | output | CW | Host ticks per bit |
| one_time | output | CW | Low width for a transmitted one |
| thr_time | output | CW | Sample point for received bits |
| zero_time | output | CW | Low width for a transmitted zero |

## Verification
The hardest case to reach is right after release. The synchronizer still shows the stale low of the request, and the target answer can be as short as a single cycle. A naive design would count the stale low as the reply. The bench models the target with a behavioural process that starts its reply a fixed delay after it sees the host let go. It then sweeps every reply width from 1 to 300 cycles, which crosses the minimum-count boundary and every rounding residue. Replies that never come, or that outlast the window, reach the timeout path.

// File: rtl/sync_pkg.sv
`timescale 1ns/1ps
package sync_pkg;
  typedef enum logic [1:0] {LS_NONE = 2'd0, LS_SYNCED = 2'd1, LS_MANUAL = 2'd2} link_e;
  typedef enum logic [1:0] {D_IDLE, D_LOW, D_HI} drv_e;
  typedef enum logic [1:0] {M_IDLE, M_HIGH, M_FALL, M_LOW} meas_e;
endpackage

// File: rtl/sync_drive.sv
`timescale 1ns/1ps
module sync_drive import sync_pkg::*; #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [CW-1:0] len,
  output logic          drv_en,
  output logic          drv_val,
  output logic          fin
);
  drv_e          ph;
  logic [CW-1:0] n;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph  <= D_IDLE;
      n   <= '0;
      fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (ph)
        D_IDLE: if (go) begin ph <= D_LOW; n <= CW'(1); end
        D_LOW:  if (n >= len) ph <= D_HI; else n <= n + CW'(1);
        D_HI:   begin ph <= D_IDLE; fin <= 1'b1; end
        default: ph <= D_IDLE;
      endcase
    end
  end

  assign drv_en  = (ph != D_IDLE);
  assign drv_val = (ph == D_HI);

  AST_SPEEDUP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (drv_en && drv_val) |=> !drv_en) else $error("speedup longer than one cycle"); // R2
  AST_LOW_BEFORE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (drv_en && drv_val) |-> $past(drv_en && !drv_val)) else $error("speedup without low phase"); // R2
endmodule

// File: rtl/sync_meas.sv
`timescale 1ns/1ps
module sync_meas import sync_pkg::*; #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic          line_in,
  input  logic [CW-1:0] tmo,
  output logic          fin,
  output logic [CW-1:0] res
);
  logic          s1, s2;
  meas_e         st;
  logic [CW-1:0] win, cnt;
  logic          expire;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= line_in;
      s2 <= s1;
    end
  end

  assign expire = ({1'b0, win} + (CW+1)'(1)) >= {1'b0, tmo};

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= M_IDLE;
      win <= '0;
      cnt <= '0;
      res <= '0;
      fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (st == M_IDLE) begin
        if (arm) begin st <= M_HIGH; win <= '0; end
      end else if (expire) begin
        st  <= M_IDLE;
        res <= '0;
        fin <= 1'b1;
      end else begin
        win <= win + CW'(1);
        case (st)
          M_HIGH: if (s2) st <= M_FALL;
          M_FALL: if (!s2) begin st <= M_LOW; cnt <= CW'(1); end
          M_LOW:  if (s2) begin st <= M_IDLE; res <= cnt; fin <= 1'b1; end
                  else cnt <= cnt + CW'(1);
          default: st <= M_IDLE;
        endcase
      end
    end
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (st == M_LOW) |=> (st == M_IDLE) || (cnt == $past(cnt) + CW'(1))) else $error("count skipped"); // R3
  AST_FIN_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fin |=> !fin) else $error("finish not a pulse"); // R7
endmodule

// File: rtl/sync_calc.sv
`timescale 1ns/1ps
module sync_calc import sync_pkg::*; #(
  parameter int CW      = 16,
  parameter int MIN_CNT = 64,
  parameter int DEF_CNT = 1024
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] cnt_in,
  input  link_e         mode_in,
  output link_e         mode,
  output logic [CW-1:0] sync_cnt,
  output logic [CW-1:0] bit_time,
  output logic [CW-1:0] one_time,
  output logic [CW-1:0] thr_time,
  output logic [CW-1:0] zero_time,
  output logic          done
);
  localparam int            XW    = CW + 7;
  localparam logic [CW-1:0] MIN_L = CW'(MIN_CNT);
  localparam logic [CW-1:0] DEF_L = CW'(DEF_CNT);

  // (c*num + add) / 128, all fractions expressed in 1/128 of the count
  function automatic logic [CW-1:0] scale(input logic [CW-1:0] c,
                                          input logic [4:0] num,
                                          input logic [6:0] add);
    logic [XW-1:0] p;
    p = XW'(c) * XW'(num) + XW'(add);
    return p[CW+6:7];
  endfunction

  logic [CW-1:0] src;
  assign src = (cnt_in < MIN_L) ? DEF_L : cnt_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= LS_NONE;
      sync_cnt  <= '0;
      bit_time  <= scale(DEF_L, 5'd16, 7'd127);
      one_time  <= scale(DEF_L, 5'd4,  7'd64);
      thr_time  <= scale(DEF_L, 5'd10, 7'd64);
      zero_time <= scale(DEF_L, 5'd13, 7'd64);
      done      <= 1'b0;
    end else begin
      done <= load;
      if (load) begin
        mode      <= mode_in;
        sync_cnt  <= cnt_in;
        bit_time  <= scale(src, 5'd16, 7'd127);
        one_time  <= scale(src, 5'd4,  7'd64);
        thr_time  <= scale(src, 5'd10, 7'd64);
        zero_time <= scale(src, 5'd13, 7'd64);
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done longer than one cycle"); // R3
  AST_NONE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (done && mode == LS_NONE) |-> (sync_cnt == '0)) else $error("no-link with count"); // R7
  AST_BIT_COVERS: assert property (@(posedge clk) disable iff (rst)
    (done && sync_cnt >= MIN_L) |-> ({3'b000, bit_time} << 3) >= {3'b000, sync_cnt}) else $error("bit time short"); // R4
  AST_ORDERED: assert property (@(posedge clk) disable iff (rst)
    done |-> (one_time <= thr_time) && (thr_time <= zero_time)) else $error("fractions out of order"); // R5
endmodule

// File: rtl/sync_rate_meter.sv
`timescale 1ns/1ps
module sync_rate_meter import sync_pkg::*; #(
  parameter int CW      = 16,
  parameter int MIN_CNT = 64,
  parameter int DEF_CNT = 1024
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] req_len,
  input  logic [CW-1:0] tmo_len,
  input  logic [CW-1:0] man_cnt,
  input  logic          line_in,
  output logic          drv_en,
  output logic          drv_val,
  output logic          busy,
  output logic          done,
  output logic [1:0]    link_state,
  output logic [CW-1:0] sync_cnt,
  output logic [CW-1:0] bit_time,
  output logic [CW-1:0] one_time,
  output logic [CW-1:0] thr_time,
  output logic [CW-1:0] zero_time
);
  logic          busy_r, req_go, man_go, drv_fin, meas_fin;
  logic [CW-1:0] meas_res, cnt_sel;
  link_e         mode_sel, mode_q;

  assign man_go = start && !busy_r && (man_cnt != '0);
  assign req_go = start && !busy_r && (man_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)           busy_r <= 1'b0;
    else if (req_go)   busy_r <= 1'b1;
    else if (meas_fin) busy_r <= 1'b0;
  end

  sync_drive #(.CW(CW)) u_drive (
    .clk(clk), .rst(rst), .go(req_go), .len(req_len),
    .drv_en(drv_en), .drv_val(drv_val), .fin(drv_fin)
  );

  sync_meas #(.CW(CW)) u_meas (
    .clk(clk), .rst(rst), .arm(drv_fin), .line_in(line_in), .tmo(tmo_len),
    .fin(meas_fin), .res(meas_res)
  );

  always_comb begin
    cnt_sel = man_go ? man_cnt : meas_res;
    if (man_go)              mode_sel = LS_MANUAL;
    else if (meas_res != '0) mode_sel = LS_SYNCED;
    else                     mode_sel = LS_NONE;
  end

  sync_calc #(.CW(CW), .MIN_CNT(MIN_CNT), .DEF_CNT(DEF_CNT)) u_calc (
    .clk(clk), .rst(rst), .load(man_go || meas_fin), .cnt_in(cnt_sel),
    .mode_in(mode_sel), .mode(mode_q), .sync_cnt(sync_cnt),
    .bit_time(bit_time), .one_time(one_time), .thr_time(thr_time),
    .zero_time(zero_time), .done(done)
  );

  assign busy       = busy_r;
  assign link_state = mode_q;

  AST_MANUAL_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    man_go |=> !drv_en && done) else $error("manual load touched the line"); // R8
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !busy_r |-> !drv_en) else $error("line driven while idle"); // R2
endmodule

// File: tb/test_sync_rate_meter.sv
`timescale 1ns/1ps
module test_sync_rate_meter;
  localparam int CW = 16, MINC = 64, DEFC = 1024, TDLY = 16;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [CW-1:0] req_len = '0, tmo_len = '0, man_cnt = '0;
  logic drv_en, drv_val, busy, done, line_in;
  logic [1:0] link_state;
  logic [CW-1:0] sync_cnt, bit_time, one_time, thr_time, zero_time;

  int total = 0, bad = 0, lo_n = 0, hi_n = 0, tgt_w = 0;
  bit tgt_on = 1'b0, tgt_low = 1'b0, finished = 1'b0, prev_en = 1'b0;

  always #5 clk = ~clk;

  assign line_in = drv_en ? drv_val : ~tgt_low;

  sync_rate_meter #(.CW(CW), .MIN_CNT(MINC), .DEF_CNT(DEFC)) i_sync_rate_meter (
    .clk(clk), .rst(rst), .start(start), .req_len(req_len), .tmo_len(tmo_len),
    .man_cnt(man_cnt), .line_in(line_in), .drv_en(drv_en), .drv_val(drv_val),
    .busy(busy), .done(done), .link_state(link_state), .sync_cnt(sync_cnt),
    .bit_time(bit_time), .one_time(one_time), .thr_time(thr_time), .zero_time(zero_time)
  );

  // behavioural target: answers a fixed delay after the host lets go
  initial begin
    forever begin
      @(negedge clk);
      if (prev_en && !drv_en && tgt_on) begin
        repeat (TDLY) @(negedge clk);
        tgt_low = 1'b1;
        repeat (tgt_w) @(negedge clk);
        tgt_low = 1'b0;
      end
      prev_en = drv_en;
    end
  end

  always @(negedge clk) begin
    if (drv_en && !drv_val) lo_n++;
    if (drv_en && drv_val)  hi_n++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int frac(input int c, input int num, input int add);
    int s;
    s = (c < MINC) ? DEFC : c;
    return (s * num + add) / 128;
  endfunction

  task automatic chk_timing(input string tag, input int c);
    chk({tag, " bit_time (R4)"},  bit_time,  frac(c, 16, 127));
    chk({tag, " one_time (R5)"},  one_time,  frac(c, 4, 64));
    chk({tag, " thr_time (R5)"},  thr_time,  frac(c, 10, 64));
    chk({tag, " zero_time (R5)"}, zero_time, frac(c, 13, 64));
  endtask

  task automatic wait_done(output bit got);
    got = 1'b0;
    for (int i = 0; i < 5000 && !got; i++) begin
      @(negedge clk);
      if (done) got = 1'b1;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    lo_n = 0; hi_n = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_sync(input int w, input bit respond, input int rl, input int tmo,
                          input int exp_cnt, input string tag);
    bit got;
    tgt_w = w; tgt_on = respond;
    req_len = CW'(rl); tmo_len = CW'(tmo); man_cnt = '0;
    pulse_start();
    wait_done(got);
    chk({tag, " done seen (R3)"}, got, 1);
    chk({tag, " low drive (R2)"}, lo_n, (rl < 1) ? 1 : rl);
    chk({tag, " speedup (R2)"}, hi_n, 1);
    chk({tag, " count"}, sync_cnt, exp_cnt);
    chk({tag, " state"}, link_state, (exp_cnt != 0) ? 1 : 0);
    chk_timing(tag, exp_cnt);
    @(negedge clk);
    chk({tag, " done one cycle (R3)"}, done, 0);
    repeat (TDLY + 4) @(negedge clk);
  endtask

  task automatic run_manual(input int m);
    bit got;
    man_cnt = CW'(m);
    pulse_start();
    chk("R8 done next cycle", done, 1);
    got = done;
    if (!got) wait_done(got);
    chk("R8 no drive", lo_n + hi_n, 0);
    chk("R8 count", sync_cnt, m);
    chk("R8 state", link_state, 2);
    chk_timing("R8", m);
    man_cnt = '0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 state", link_state, 0);
    chk("R1 count", sync_cnt, 0);
    chk("R1 drv_en", drv_en, 0);
    chk("R1 done", done, 0);
    chk_timing("R1", 0);

    // exhaustive reply widths, crossing the MIN_CNT boundary (R6 below 64)
    for (int w = 1; w <= 300; w++)
      run_sync(w, 1'b1, 20 + (w % 7), 2000, w, (w < MINC) ? "R6 sweep" : "R3 sweep");

    run_sync(0, 1'b1, 0, 2000, 0, "R2 zero length");
    tgt_w = 5;
    run_sync(5, 1'b1, 0, 2000, 5, "R2 zero length reply");
    run_sync(0, 1'b0, 30, 200, 0, "R7 no target");
    run_sync(500, 1'b1, 30, 300, 0, "R7 reply too long");
    repeat (520) @(negedge clk);
    run_manual(300);
    run_manual(40);
    run_manual(1024);
    run_sync(128, 1'b1, 150, 2000, 128, "R3 after manual");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule